// File: doc/BRIEF.md
# CAN Receive Message Buffer Store Controller

This block sits behind an already-decoded CAN receive path. For each accepted standard-format frame it writes the 11-bit identifier, the length code and up to eight data bytes into one of 32 message buffers in a single-port RAM. Each buffer has three flags: a ready bit written by software, a data-new flag, and an update-in-progress flag. Software uses these flags to tell whether a buffer changed while it was reading it.

A frame arrives on a valid/ready stream. The transfer takes place on a rising edge where `fr_valid` and `fr_ready` are both high. `fr_ready` is low while a store is still running and in any cycle with a CPU access. A frame aimed at a buffer whose ready bit is 0 is taken and dropped. For a ready buffer, the accepting edge sets data-new and update-in-progress together and logs the buffer index in an 8-entry history stream. The engine then writes three RAM words, one per cycle. Any CPU access takes precedence over the engine and holds it for that cycle. The edge that writes the last word sets data-new again and clears update-in-progress. The history output is a valid/ready stream: an entry stays on `hist_idx` until `hist_ready` takes it. If the list is full, the newest index is dropped and a sticky overflow flag is raised. The flag stays set until reset.

For a consistent read, software first clears data-new, then reads the buffer words, then reads the control word. Both data-new and update-in-progress must read 0 at that point for the read to be valid.

Top module: `rxmb_store_ctrl`

## Requirements
- R1: After reset every ready, data-new and update-in-progress flag is 0, `hist_valid` and `hist_ovf` are 0, and `fr_ready` is 1 while `cpu_req` is 0.
- R2: `fr_ready` is 1 exactly when no store is running and `cpu_req` is 0. A frame transfers on a rising edge with `fr_valid` and `fr_ready` both high.
- R3: When a frame to a buffer with ready = 1 transfers, that buffer's data-new and update-in-progress flags both read 1 from the next cycle.
- R4: Without CPU accesses, the store writes its three words on the three edges after acceptance. On the third of these edges, data-new is set to 1 and update-in-progress is cleared, and `fr_ready` returns to 1 at the same edge.
- R5: The history entry for the target buffer becomes visible on the edge of acceptance, while update-in-progress of that buffer is still 1.
- R6: A frame to a buffer whose ready bit is 0 is consumed without a store. No flag changes, no history entry is added, and `fr_ready` stays 1.
- R7: The control word is `cpu_sel` = 3. A write with bit 8 set loads the ready bit from bit 0, and a write with bit 9 set clears data-new. A read returns ready in bit 0, data-new in bit 1 and update-in-progress in bit 2. A ready-bit write to a buffer whose update-in-progress is 1 is ignored.
- R8: Any CPU access (`cpu_req` = 1) blocks the store engine for that cycle. Each blocked cycle delays completion by one cycle.
- R9: RAM layout: word 0 holds the identifier in bits 10:0 and the raw length code in bits 14:11. Word 1 holds data bytes 0 to 3 and word 2 holds bytes 4 to 7, byte 0 in bits 7:0. Bytes at or beyond min(length code, 8) are stored as 0. Byte k of `fr_data` is bits 8k+7:8k.
- R10: The history list holds 8 indices, first in, first out. An entry is held stable while `hist_ready` is 0. A push into a full list that is not being popped in the same cycle is dropped and sets `hist_ovf`, which then stays 1 until reset.
- R11: A CPU read (`cpu_req` = 1, `cpu_we` = 0) returns its data on `cpu_rdata` with `cpu_rvalid` = 1 in the next cycle. A CPU write to words 0 to 2 updates the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | Frame offered |
| fr_ready | output | 1 | Frame can transfer this cycle |
| fr_buf | input | 5 | Target buffer index |
| fr_id | input | 11 | Standard identifier |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| cpu_req | input | 1 | CPU access this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_buf | input | 5 | CPU buffer index |
| cpu_sel | input | 2 | Word select: 0 header, 1 low data, 2 high data, 3 control |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Read data |
| hist_valid | output | 1 | History entry available |
| hist_ready | input | 1 | History entry taken |
| hist_idx | output | 5 | Oldest logged buffer index |
| hist_ovf | output | 1 | Sticky history overflow |

## Verification
Two pairs of events can fall in the same cycle. The first is a CPU access together with a pending word write of the store engine. The bench provokes it by reading or writing a buffer in the cycles right after a frame is accepted. It then checks that the engine finishes one cycle later for each cycle the CPU held the RAM, and that the stored words are intact. The second is a CPU ready-bit write arriving while the target buffer is being updated. The bench issues it in the middle of a store, with a data-new clear in the same write. A later control-word read must show the ready bit unchanged, and data-new set again by completion. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam int ID_W      = 11;
  localparam int DLC_W     = 4;
  localparam int DATA_W    = 64;
  localparam int WORD_W    = 32;
  localparam int MAX_BYTES = DATA_W / 8;

  localparam logic [1:0] WSEL_HDR  = 2'd0;
  localparam logic [1:0] WSEL_LO   = 2'd1;
  localparam logic [1:0] WSEL_HI   = 2'd2;
  localparam logic [1:0] WSEL_CTRL = 2'd3;

  localparam int CB_RDY    = 0;
  localparam int CB_DN     = 1;
  localparam int CB_MUC    = 2;
  localparam int CB_RDY_WE = 8;
  localparam int CB_DN_CLR = 9;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_HDR  = 2'd1,
    ENG_LO   = 2'd2,
    ENG_HI   = 2'd3
  } eng_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
    logic [WORD_W-1:0] hdr;
  } mb_image_t;
endpackage

// File: rtl/rxmb_ram.sv
module rxmb_ram #(
  parameter int ADDR_W = 7,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/rxmb_flags.sv
module rxmb_flags #(
  parameter int NUM_BUF = 32,
  parameter int BUF_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_fire,
  input  logic [BUF_W-1:0]   acc_buf,
  input  logic               done,
  input  logic [BUF_W-1:0]   done_buf,
  input  logic               ctl_we,
  input  logic [BUF_W-1:0]   ctl_buf,
  input  logic               rdy_we,
  input  logic               rdy_val,
  input  logic               dn_clr,
  output logic [NUM_BUF-1:0] rdy_vec,
  output logic [NUM_BUF-1:0] dn_vec,
  output logic [NUM_BUF-1:0] muc_vec
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic hit_acc, hit_done, hit_ctl;
    assign hit_acc  = acc_fire && (acc_buf  == BUF_W'(i));
    assign hit_done = done     && (done_buf == BUF_W'(i));
    assign hit_ctl  = ctl_we   && (ctl_buf  == BUF_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_vec[i] <= 1'b0;
        dn_vec[i]  <= 1'b0;
        muc_vec[i] <= 1'b0;
      end else begin
        if (hit_ctl && rdy_we && !muc_vec[i])
          rdy_vec[i] <= rdy_val;
        if (hit_acc || hit_done)
          dn_vec[i] <= 1'b1;
        else if (hit_ctl && dn_clr)
          dn_vec[i] <= 1'b0;
        if (hit_acc)
          muc_vec[i] <= 1'b1;
        else if (hit_done)
          muc_vec[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxmb_hist_fifo.sv
module rxmb_hist_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop, do_push;

  assign out_valid = (cnt != '0);
  assign out_data  = store[rd_ptr];
  assign pop       = out_valid && out_ready;
  assign do_push   = push && ((cnt != CW'(DEPTH)) || pop);

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !do_push) cnt <= cnt - 1'b1;
      if (push && !do_push) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/rxmb_store_eng.sv
module rxmb_store_eng
  import rxmb_pkg::*;
#(
  parameter int BUF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [BUF_W-1:0]  fr_buf,
  input  logic [ID_W-1:0]   fr_id,
  input  logic [DLC_W-1:0]  fr_dlc,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              tgt_rdy,
  input  logic              cpu_busy,
  output logic              acc_fire,
  output logic              wr_req,
  output logic              wr_gnt,
  output logic [BUF_W-1:0]  wr_buf,
  output logic [1:0]        wr_sel,
  output logic [WORD_W-1:0] wr_data,
  output logic              done
);
  eng_state_t        st_q;
  mb_image_t         img_d, img_q;
  logic [BUF_W-1:0]  buf_q;
  logic [DLC_W-1:0]  nbytes;
  logic [DATA_W-1:0] masked;

  assign nbytes = (fr_dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : fr_dlc;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_mask
    assign masked[k*8 +: 8] = (DLC_W'(k) < nbytes) ? fr_data[k*8 +: 8] : 8'h00;
  end

  always_comb begin
    img_d.hdr = {{(WORD_W-DLC_W-ID_W){1'b0}}, fr_dlc, fr_id};
    img_d.lo  = masked[WORD_W-1:0];
    img_d.hi  = masked[DATA_W-1:WORD_W];
  end

  assign fr_ready = (st_q == ENG_IDLE) && !cpu_busy;
  assign acc_fire = fr_valid && fr_ready && tgt_rdy;
  assign wr_req   = (st_q != ENG_IDLE);
  assign wr_gnt   = wr_req && !cpu_busy;
  assign wr_buf   = buf_q;
  assign done     = wr_gnt && (st_q == ENG_HI);

  always_comb begin
    unique case (st_q)
      ENG_LO:  begin wr_sel = WSEL_LO;  wr_data = img_q.lo;  end
      ENG_HI:  begin wr_sel = WSEL_HI;  wr_data = img_q.hi;  end
      default: begin wr_sel = WSEL_HDR; wr_data = img_q.hdr; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      buf_q <= '0;
      img_q <= '0;
    end else begin
      if (acc_fire) begin
        st_q  <= ENG_HDR;
        buf_q <= fr_buf;
        img_q <= img_d;
      end else if (wr_gnt) begin
        unique case (st_q)
          ENG_HDR: st_q <= ENG_LO;
          ENG_LO:  st_q <= ENG_HI;
          default: st_q <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxmb_store_ctrl.sv
module rxmb_store_ctrl
  import rxmb_pkg::*;
#(
  parameter int NUM_BUF    = 32,
  parameter int HIST_DEPTH = 8,
  parameter int BUF_W      = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [BUF_W-1:0]  fr_buf,
  input  logic [ID_W-1:0]   fr_id,
  input  logic [DLC_W-1:0]  fr_dlc,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [BUF_W-1:0]  cpu_buf,
  input  logic [1:0]        cpu_sel,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              hist_valid,
  input  logic              hist_ready,
  output logic [BUF_W-1:0]  hist_idx,
  output logic              hist_ovf
);
  localparam int ADDR_W = BUF_W + 2;

  logic [NUM_BUF-1:0] rdy_vec, dn_vec, muc_vec;
  logic               acc_fire, eng_wr_req, eng_wr_gnt, eng_done;
  logic [BUF_W-1:0]   eng_buf;
  logic [1:0]         eng_sel;
  logic [WORD_W-1:0]  eng_data;
  logic               cpu_ctl, cpu_ram;
  logic               ram_en, ram_we;
  logic [ADDR_W-1:0]  ram_addr;
  logic [WORD_W-1:0]  ram_wdata, ram_rdata;
  logic               rd_ctl_q, rvalid_q;
  logic [WORD_W-1:0]  ctl_snap_q;

  assign cpu_ctl = cpu_req && (cpu_sel == WSEL_CTRL);
  assign cpu_ram = cpu_req && (cpu_sel != WSEL_CTRL);

  rxmb_store_eng #(.BUF_W(BUF_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_buf(fr_buf),
    .fr_id(fr_id), .fr_dlc(fr_dlc), .fr_data(fr_data),
    .tgt_rdy(rdy_vec[fr_buf]), .cpu_busy(cpu_req),
    .acc_fire(acc_fire), .wr_req(eng_wr_req), .wr_gnt(eng_wr_gnt),
    .wr_buf(eng_buf), .wr_sel(eng_sel), .wr_data(eng_data), .done(eng_done)
  );

  rxmb_flags #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .acc_fire(acc_fire), .acc_buf(fr_buf),
    .done(eng_done), .done_buf(eng_buf),
    .ctl_we(cpu_ctl && cpu_we), .ctl_buf(cpu_buf),
    .rdy_we(cpu_wdata[CB_RDY_WE]), .rdy_val(cpu_wdata[CB_RDY]),
    .dn_clr(cpu_wdata[CB_DN_CLR]),
    .rdy_vec(rdy_vec), .dn_vec(dn_vec), .muc_vec(muc_vec)
  );

  rxmb_hist_fifo #(.DEPTH(HIST_DEPTH), .W(BUF_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .push(acc_fire), .push_data(fr_buf),
    .out_valid(hist_valid), .out_ready(hist_ready), .out_data(hist_idx),
    .ovf(hist_ovf)
  );

  // CPU wins the single RAM port; engine only writes on its grant.
  always_comb begin
    if (cpu_ram) begin
      ram_en    = 1'b1;
      ram_we    = cpu_we;
      ram_addr  = {cpu_buf, cpu_sel};
      ram_wdata = cpu_wdata;
    end else begin
      ram_en    = eng_wr_gnt;
      ram_we    = eng_wr_gnt;
      ram_addr  = {eng_buf, eng_sel};
      ram_wdata = eng_data;
    end
  end

  rxmb_ram #(.ADDR_W(ADDR_W), .DW(WORD_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      rd_ctl_q   <= 1'b0;
      ctl_snap_q <= '0;
    end else begin
      rvalid_q <= cpu_req && !cpu_we;
      if (cpu_req && !cpu_we) begin
        rd_ctl_q   <= cpu_ctl;
        ctl_snap_q <= {{(WORD_W-3){1'b0}}, muc_vec[cpu_buf], dn_vec[cpu_buf], rdy_vec[cpu_buf]};
      end
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rd_ctl_q ? ctl_snap_q : ram_rdata;
endmodule

// File: rtl/rxmb_store_ctrl_sva.sv
module rxmb_store_ctrl_sva #(
  parameter int NUM_BUF = 32,
  parameter int BUF_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fr_valid,
  input logic               fr_ready,
  input logic [BUF_W-1:0]   fr_buf,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic [BUF_W-1:0]   cpu_buf,
  input logic [1:0]         cpu_sel,
  input logic               cpu_rdy_we,
  input logic               hist_valid,
  input logic               hist_ready,
  input logic [BUF_W-1:0]   hist_idx,
  input logic               hist_ovf,
  input logic [NUM_BUF-1:0] rdy_vec,
  input logic [NUM_BUF-1:0] dn_vec,
  input logic [NUM_BUF-1:0] muc_vec,
  input logic               eng_wr_gnt
);
  AST_ACCEPT_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && fr_ready && rdy_vec[fr_buf] |=> dn_vec[$past(fr_buf)] && muc_vec[$past(fr_buf)]); // R3
  AST_DISCARD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && fr_ready && !rdy_vec[fr_buf] |=> (muc_vec == '0) && (dn_vec == $past(dn_vec))); // R6
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_ready |-> !cpu_req && (muc_vec == '0)); // R2
  AST_READY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && (cpu_sel == 2'd3) && cpu_rdy_we && muc_vec[cpu_buf] |=> rdy_vec == $past(rdy_vec)); // R7
  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !eng_wr_gnt); // R8
  AST_SINGLE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(muc_vec)); // R4
  AST_HISTORY_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid && fr_ready && rdy_vec[fr_buf] |=> hist_valid || hist_ovf); // R5
  AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hist_valid && !hist_ready |=> hist_valid && (hist_idx == $past(hist_idx))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ovf |=> hist_ovf); // R10
endmodule

bind rxmb_store_ctrl rxmb_store_ctrl_sva #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_buf(fr_buf),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_buf(cpu_buf), .cpu_sel(cpu_sel),
  .cpu_rdy_we(cpu_wdata[8]),
  .hist_valid(hist_valid), .hist_ready(hist_ready), .hist_idx(hist_idx), .hist_ovf(hist_ovf),
  .rdy_vec(rdy_vec), .dn_vec(dn_vec), .muc_vec(muc_vec), .eng_wr_gnt(eng_wr_gnt)
);

// File: tb/rxmb_store_ctrl_bench.sv
module rxmb_store_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_valid = 1'b0;
  logic        fr_ready;
  logic [4:0]  fr_buf = '0;
  logic [10:0] fr_id = '0;
  logic [3:0]  fr_dlc = '0;
  logic [63:0] fr_data = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [4:0]  cpu_buf = '0;
  logic [1:0]  cpu_sel = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        hist_valid, hist_ovf;
  logic        hist_ready = 1'b0;
  logic [4:0]  hist_idx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rxmb_store_ctrl u_rxmb_store_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_buf(fr_buf),
    .fr_id(fr_id), .fr_dlc(fr_dlc), .fr_data(fr_data),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_buf(cpu_buf), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .hist_valid(hist_valid), .hist_ready(hist_ready), .hist_idx(hist_idx),
    .hist_ovf(hist_ovf)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_rdy [32];
  bit          m_dn  [32];
  bit          m_muc [32];
  logic [31:0] m_mem [128];
  int          hq [$];
  bit          m_ovf, m_busy, m_rvalid;
  int          m_step, m_buf;
  logic [31:0] m_img [3];
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin m_rdy[i] = 0; m_dn[i] = 0; m_muc[i] = 0; end
      hq.delete();
      m_ovf = 0; m_busy = 0; m_rvalid = 0; m_step = 0; m_buf = 0;
    end else begin
      bit pop, acc;
      pop = hist_ready && (hq.size() > 0);
      acc = fr_valid && !m_busy && !cpu_req;
      m_rvalid = cpu_req && !cpu_we;
      if (m_rvalid)
        m_rdata = (cpu_sel == 2'd3) ? {29'b0, m_muc[cpu_buf], m_dn[cpu_buf], m_rdy[cpu_buf]}
                                     : m_mem[cpu_buf * 4 + cpu_sel];
      if (cpu_req && cpu_we) begin
        if (cpu_sel != 2'd3) m_mem[cpu_buf * 4 + cpu_sel] = cpu_wdata;
        else begin
          if (cpu_wdata[9]) m_dn[cpu_buf] = 0;
          if (cpu_wdata[8] && !m_muc[cpu_buf]) m_rdy[cpu_buf] = cpu_wdata[0];
        end
      end
      if (m_busy && !cpu_req) begin
        m_mem[m_buf * 4 + m_step] = m_img[m_step];
        if (m_step == 2) begin m_muc[m_buf] = 0; m_dn[m_buf] = 1; m_busy = 0; end
        else m_step++;
      end
      if (pop) void'(hq.pop_front());
      if (acc && m_rdy[fr_buf]) begin
        int n;
        logic [63:0] md;
        n  = (fr_dlc > 8) ? 8 : int'(fr_dlc);
        md = '0;
        for (int k = 0; k < 8; k++) if (k < n) md[k*8 +: 8] = fr_data[k*8 +: 8];
        m_img[0] = {17'b0, fr_dlc, fr_id};
        m_img[1] = md[31:0];
        m_img[2] = md[63:32];
        m_dn[fr_buf] = 1; m_muc[fr_buf] = 1;
        m_busy = 1; m_step = 0; m_buf = fr_buf;
        if (hq.size() < 8) hq.push_back(int'(fr_buf)); else m_ovf = 1;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic lockstep();
    chk(fr_ready === (!m_busy && !cpu_req), "R2 fr_ready", 64'(fr_ready), 64'(!m_busy && !cpu_req));
    chk(hist_valid === (hq.size() > 0), "R10 hist_valid", 64'(hist_valid), 64'(hq.size() > 0));
    if (hq.size() > 0) chk(hist_idx === 5'(hq[0]), "R10 hist_idx", 64'(hist_idx), 64'(hq[0]));
    chk(hist_ovf === m_ovf, "R10 hist_ovf", 64'(hist_ovf), 64'(m_ovf));
    chk(cpu_rvalid === m_rvalid, "R11 rvalid", 64'(cpu_rvalid), 64'(m_rvalid));
    if (m_rvalid) chk(cpu_rdata === m_rdata, "R11 rdata", 64'(cpu_rdata), 64'(m_rdata));
  endtask

  task automatic tick();
    @(negedge clk);
    lockstep();
  endtask

  task automatic cpu_wr(input int b, input int sel, input logic [31:0] d);
    cpu_req = 1; cpu_we = 1; cpu_buf = 5'(b); cpu_sel = 2'(sel); cpu_wdata = d;
    tick();
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic cpu_rd(input int b, input int sel, output logic [31:0] d);
    cpu_req = 1; cpu_we = 0; cpu_buf = 5'(b); cpu_sel = 2'(sel);
    tick();
    cpu_req = 0;
    d = cpu_rdata;
  endtask

  task automatic send(input int b, input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] d);
    bit took;
    fr_valid = 1; fr_buf = 5'(b); fr_id = id; fr_dlc = dlc; fr_data = d;
    forever begin
      #1 took = fr_ready;
      tick();
      if (took) break;
    end
    fr_valid = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!fr_ready && n < 100) begin tick(); n++; end
  endtask

  task automatic drain();
    hist_ready = 1;
    while (hist_valid) tick();
    hist_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1: reset state
    chk(fr_ready === 1'b1, "R1 fr_ready", 64'(fr_ready), 1);
    chk(hist_valid === 1'b0 && hist_ovf === 1'b0, "R1 hist", 64'({hist_valid, hist_ovf}), 0);
    cpu_rd(5, 3, d);
    chk(d === 32'h0, "R1 ctrl", 64'(d), 0);

    // R7: ready bit writes when idle
    cpu_wr(3, 3, 32'h101);
    cpu_wr(4, 3, 32'h101);
    cpu_wr(20, 3, 32'h101);
    cpu_rd(3, 3, d);
    chk(d === 32'h1, "R7 ready set", 64'(d), 1);

    // R3, R5, R8: accept then a CPU read stalls the store
    send(3, 11'h5A3, 4'd8, 64'h8877665544332211);
    chk(hist_valid === 1'b1 && hist_idx === 5'd3, "R5 history early", 64'({hist_valid, hist_idx}), 64'({1'b1, 5'd3}));
    cpu_rd(3, 3, d);
    chk(d === 32'h7, "R3 dn and muc set", 64'(d), 7);
    wait_idle(n);
    chk(n == 3, "R8 stalled completion", 64'(n), 3);
    cpu_rd(3, 3, d);
    chk(d === 32'h3, "R4 done flags", 64'(d), 3);
    cpu_rd(3, 0, d);
    chk(d === 32'h000045A3, "R9 header word", 64'(d), 64'h45A3);
    cpu_rd(3, 1, d);
    chk(d === 32'h44332211, "R9 low word", 64'(d), 64'h44332211);
    cpu_rd(3, 2, d);
    chk(d === 32'h88776655, "R9 high word", 64'(d), 64'h88776655);

    // R4: unstalled store completes on third edge after acceptance
    send(20, 11'h001, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    wait_idle(n);
    chk(n == 3, "R4 three write cycles", 64'(n), 3);
    cpu_rd(20, 1, d);
    chk(d === 32'h00FFFFFF, "R9 dlc3 mask low", 64'(d), 64'hFFFFFF);
    cpu_rd(20, 2, d);
    chk(d === 32'h0, "R9 dlc3 mask high", 64'(d), 0);
    cpu_wr(20, 3, 32'h100);
    cpu_rd(20, 3, d);
    chk(d === 32'h2, "R7 ready clear when idle", 64'(d), 2);

    // R6: frame to a buffer without ready is dropped
    drain();
    send(7, 11'h123, 4'd2, 64'hAB);
    chk(fr_ready === 1'b1 && hist_valid === 1'b0, "R6 discarded", 64'({fr_ready, hist_valid}), 64'(2'b10));
    cpu_rd(7, 3, d);
    chk(d === 32'h0, "R6 no flags", 64'(d), 0);

    // R7 lockout and R4 second data-new set
    send(4, 11'h7FF, 4'd12, 64'hF0E0D0C0B0A09080);
    cpu_wr(4, 3, 32'h300);
    cpu_rd(4, 3, d);
    chk(d === 32'h5, "R7 lockout mid-store", 64'(d), 5);
    wait_idle(n);
    cpu_rd(4, 3, d);
    chk(d === 32'h3, "R4 data-new set again", 64'(d), 3);
    cpu_rd(4, 0, d);
    chk(d === 32'h000067FF, "R9 raw dlc kept", 64'(d), 64'h67FF);
    cpu_rd(4, 2, d);
    chk(d === 32'hF0E0D0C0, "R9 dlc above 8", 64'(d), 64'hF0E0D0C0);

    // R11: CPU write to RAM word
    cpu_wr(4, 1, 32'hCAFE0001);
    cpu_rd(4, 1, d);
    chk(d === 32'hCAFE0001, "R11 cpu ram write", 64'(d), 64'hCAFE0001);

    // R10: overflow of history list
    drain();
    for (int b = 10; b < 19; b++) cpu_wr(b, 3, 32'h101);
    for (int b = 10; b < 19; b++) begin
      send(b, 11'(b), 4'd1, 64'(b));
      wait_idle(n);
    end
    chk(hist_ovf === 1'b1, "R10 overflow flag", 64'(hist_ovf), 1);
    hist_ready = 1;
    for (int b = 10; b < 18; b++) begin
      chk(hist_valid === 1'b1 && hist_idx === 5'(b), "R10 order", 64'(hist_idx), 64'(b));
      tick();
    end
    hist_ready = 0;
    chk(hist_valid === 1'b0, "R10 newest dropped", 64'(hist_valid), 0);
    tick();
    chk(hist_ovf === 1'b1, "R10 sticky", 64'(hist_ovf), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule